// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a direct-mapped branch target buffer that the fetch stage consults with the current fetch address. Every slot holds a valid flag, an address tag and a predicted target address. The lookup is purely combinational. Within the same cycle it reports whether the fetched word is a branch it has seen before. On a hit it also returns the stored target. It then picks the next fetch address from that result and from a taken/not-taken direction bit, which a separate direction predictor supplies.

Branch resolution writes back through a single update port. The port carries a two-bit command:

- `00` (UPD_IDLE): no change.
- `01` (UPD_FILL): stores the tag and target of a resolved taken branch.
- `10` (UPD_DROP): clears the valid flag of a slot, for example when a non-branch was wrongly taken to be a branch.
- `11` (UPD_RSVD): reserved, and acts as no change.

Updates take effect at the clock edge. There is no bypass from the update port to the lookup path.

The fetch address splits into three fields:

- Bits [1:0] are the byte offset and are ignored.
- Bits [IDX_W+1:2] select the slot.
- Bits [PC_W-1:IDX_W+2] form the tag.

Top module: `tgtbuf_top`

## Requirements
- R1: After reset every slot is invalid, so a lookup at any address reports no hit until a fill has been performed.
- R2: `hit` is high only when the slot selected by `fetch_pc[IDX_W+1:2]` is valid and its stored tag equals `fetch_pc[PC_W-1:IDX_W+2]`. A tag mismatch reports no hit.
- R3: On a hit, `hit_target` equals the target stored in that slot. On a miss, `hit_target` is zero.
- R4: When `hit` and `dir_taken` are both high, `next_pc` equals the stored target in the same cycle.
- R5: When `hit` is high and `dir_taken` is low, `next_pc` equals `fetch_pc + 4`.
- R6: When `hit` is low, `next_pc` equals `fetch_pc + 4` whatever the value of `dir_taken`.
- R7: `upd_op = 01` writes the tag and target of `upd_pc` into the slot it indexes and sets the slot valid from the next cycle. This replaces any previous branch that aliases to the same slot.
- R8: `upd_op = 10` clears the valid flag of the slot indexed by `upd_pc` from the next cycle, whatever the stored tag. All other slots are left unchanged.
- R9: `upd_op = 00` and `upd_op = 11` change no slot.
- R10: A lookup in the same cycle as an update to the same slot returns the contents from before the update.
- R11: Bits [1:0] of `fetch_pc` and `upd_pc` have no effect on indexing or tag matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| dir_taken | input | 1 | Direction prediction for the fetched word |
| upd_op | input | 2 | Update command: 00 idle, 01 fill, 10 drop, 11 reserved |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved target written on a fill |
| hit | output | 1 | Fetched word is a known branch |
| hit_target | output | PC_W | Stored target on a hit, zero otherwise |
| next_pc | output | PC_W | Selected next fetch address |

## Verification
The hardest case to reach from the ports is two distinct branches that alias to one slot. Only one of them can be resident at a time. A lookup for the other must miss even though the slot is valid.

The stimulus first fills every slot with a known tag. It then probes each slot with a deliberately altered tag and then refills one slot with an alias. Next it drops alternate slots and sweeps again.

A fill issued in the same cycle as a lookup of that slot exercises the missing bypass.

// File: rtl/tgtbuf_pkg.sv
package tgtbuf_pkg;
    typedef enum logic [1:0] {
        UPD_IDLE = 2'b00,
        UPD_FILL = 2'b01,
        UPD_DROP = 2'b10,
        UPD_RSVD = 2'b11
    } upd_op_e;
endpackage

// File: rtl/tgtbuf_array.sv
module tgtbuf_array
    import tgtbuf_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  upd_op_e          upd_op,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [PC_W-1:0]  upd_tgt,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt
);
    logic             fill_en, drop_en;
    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    logic [DEPTH-1:0] vld_vec;

    // command decode
    always_comb begin
        fill_en = 1'b0;
        drop_en = 1'b0;
        unique case (upd_op)
            UPD_FILL: fill_en = 1'b1;
            UPD_DROP: drop_en = 1'b1;
            UPD_IDLE,
            UPD_RSVD: ;
        endcase
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        wire sel = (upd_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q[e] <= 1'b0;
            else if (sel && fill_en)
                vld_q[e] <= 1'b1;
            else if (sel && drop_en)
                vld_q[e] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                tag_q[e] <= upd_tag;
                tgt_q[e] <= upd_tgt;
            end
        end

        assign vld_vec[e] = vld_q[e];
    end

    assign rd_vld = vld_q[rd_idx];
    assign rd_tag = tag_q[rd_idx];
    assign rd_tgt = tgt_q[rd_idx];

    // R7
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_vec[$past(upd_idx)]);

    // R8
    drop_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en |=> !vld_vec[$past(upd_idx)]);

    // R9
    idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_op == UPD_IDLE || upd_op == UPD_RSVD) |=> $stable(vld_vec));
endmodule

// File: rtl/tgtbuf_nextpc.sv
module tgtbuf_nextpc #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             dir_taken,
    input  logic             rd_vld,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [PC_W-1:0]  rd_tgt,
    output logic             hit,
    output logic [PC_W-1:0]  hit_target,
    output logic [PC_W-1:0]  next_pc
);
    logic [TAG_W-1:0] pc_tag;
    logic [PC_W-1:0]  seq_pc;

    assign pc_tag = fetch_pc[PC_W-1 -: TAG_W];
    assign seq_pc = fetch_pc + PC_W'(4);

    always_comb begin
        hit        = rd_vld && (rd_tag == pc_tag);
        hit_target = hit ? rd_tgt : '0;
        next_pc    = (hit && dir_taken) ? rd_tgt : seq_pc;
    end
endmodule

// File: rtl/tgtbuf_top.sv
module tgtbuf_top
    import tgtbuf_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            dir_taken,
    input  logic [1:0]      upd_op,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    output logic            hit,
    output logic [PC_W-1:0] hit_target,
    output logic [PC_W-1:0] next_pc
);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic             rd_vld;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_tgt;

    tgtbuf_array #(.PC_W(PC_W), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_pc[IDX_W+1:2]),
        .upd_op  (upd_op_e'(upd_op)),
        .upd_idx (upd_pc[IDX_W+1:2]),
        .upd_tag (upd_pc[PC_W-1 -: TAG_W]),
        .upd_tgt (upd_target),
        .rd_vld  (rd_vld),
        .rd_tag  (rd_tag),
        .rd_tgt  (rd_tgt)
    );

    tgtbuf_nextpc #(.PC_W(PC_W), .IDX_W(IDX_W)) u_nextpc (
        .fetch_pc   (fetch_pc),
        .dir_taken  (dir_taken),
        .rd_vld     (rd_vld),
        .rd_tag     (rd_tag),
        .rd_tgt     (rd_tgt),
        .hit        (hit),
        .hit_target (hit_target),
        .next_pc    (next_pc)
    );

    // R1
    reset_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !hit);

    // R4
    taken_hit_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && dir_taken) |-> (next_pc == hit_target));

    // R6
    miss_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (next_pc == fetch_pc + PC_W'(4) && hit_target == '0));
endmodule

// File: tb/sim_tgtbuf_top.sv
module sim_tgtbuf_top;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            dir_taken = 1'b0;
    logic [1:0]      upd_op = 2'b00;
    logic [PC_W-1:0] upd_pc = '0;
    logic [PC_W-1:0] upd_target = '0;
    logic            hit;
    logic [PC_W-1:0] hit_target, next_pc;

    int nchk = 0;
    int nerr = 0;

    logic             m_v   [DEPTH];
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    tgtbuf_top #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .dir_taken(dir_taken),
        .upd_op(upd_op), .upd_pc(upd_pc), .upd_target(upd_target),
        .hit(hit), .hit_target(hit_target), .next_pc(next_pc)
    );

    function automatic logic [PC_W-1:0] mk_pc(int idx, logic [TAG_W-1:0] tag, int low);
        return {tag, IDX_W'(idx), 2'(low)};
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(int i);
        return TAG_W'(i * 37 + 5);
    endfunction

    task automatic check(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a lookup and compare all outputs against the bench model
    task automatic look(string req, logic [PC_W-1:0] pc, logic dir);
        logic [IDX_W-1:0] ix;
        logic             h;
        logic [PC_W-1:0]  t;
        @(negedge clk);
        upd_op    = 2'b00;
        fetch_pc  = pc;
        dir_taken = dir;
        #1;
        ix = pc[IDX_W+1:2];
        h  = m_v[ix] && (m_tag[ix] == pc[PC_W-1 -: TAG_W]);
        t  = h ? m_tgt[ix] : '0;
        check({req, " hit"}, PC_W'(hit), PC_W'(h));
        check({req, " target"}, hit_target, t);
        check({req, " next_pc"}, next_pc, (h && dir) ? t : pc + 4);
    endtask

    task automatic upd(logic [1:0] op, logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt);
        logic [IDX_W-1:0] ix;
        @(negedge clk);
        upd_op     = op;
        upd_pc     = pc;
        upd_target = tgt;
        @(posedge clk);
        ix = pc[IDX_W+1:2];
        if (op == 2'b01) begin
            m_v[ix] = 1'b1; m_tag[ix] = pc[PC_W-1 -: TAG_W]; m_tgt[ix] = tgt;
        end else if (op == 2'b10) begin
            m_v[ix] = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every slot misses after reset
        for (int i = 0; i < DEPTH; i++) look("R1", mk_pc(i, tag_of(i), 0), 1'b1);

        // R7: fill every slot
        for (int i = 0; i < DEPTH; i++)
            upd(2'b01, mk_pc(i, tag_of(i), i % 4), 32'h1000_0000 + 32'(i * 64));

        // R2 R3 R4 R5 R11: sweep with both directions and all byte offsets
        for (int i = 0; i < DEPTH; i++) begin
            for (int lo = 0; lo < 4; lo++) begin
                look("R4 R11", mk_pc(i, tag_of(i), lo), 1'b1);
                look("R5 R11", mk_pc(i, tag_of(i), lo), 1'b0);
            end
            // R2 R6: wrong tag on a valid slot must miss
            look("R2 R6", mk_pc(i, tag_of(i) ^ TAG_W'(1 << (i % TAG_W)), 0), 1'b1);
        end

        // R7: an aliasing branch evicts the resident one
        upd(2'b01, mk_pc(5, tag_of(99), 0), 32'hABCD_0010);
        look("R7 alias new", mk_pc(5, tag_of(99), 0), 1'b1);
        look("R7 alias old", mk_pc(5, tag_of(5), 0), 1'b1);

        // R8: drop odd slots with unrelated tags
        for (int i = 1; i < DEPTH; i += 2) upd(2'b10, mk_pc(i, tag_of(200), 3), '0);
        for (int i = 0; i < DEPTH; i++) look("R8", mk_pc(i, tag_of(i), 0), 1'b1);

        // R9: idle and reserved commands touch nothing
        upd(2'b00, mk_pc(2, tag_of(77), 0), 32'h5555_0000);
        upd(2'b11, mk_pc(3, tag_of(78), 0), 32'h6666_0000);
        upd(2'b11, mk_pc(4, tag_of(4), 0), 32'h7777_0000);
        look("R9 idle", mk_pc(2, tag_of(2), 0), 1'b1);
        look("R9 rsvd miss", mk_pc(3, tag_of(78), 0), 1'b1);
        look("R9 rsvd keep", mk_pc(4, tag_of(4), 0), 1'b1);

        // R10: lookup concurrent with a fill of the same slot sees old data
        @(negedge clk);
        upd_op = 2'b01; upd_pc = mk_pc(6, tag_of(6), 0); upd_target = 32'h0BAD_0000;
        fetch_pc = mk_pc(6, tag_of(6), 0); dir_taken = 1'b1;
        #1;
        check("R10 same-cycle target", hit_target, m_tgt[6]);
        @(posedge clk);
        m_tgt[6] = 32'h0BAD_0000;
        look("R10 after", mk_pc(6, tag_of(6), 0), 1'b1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule